// File: doc/BRIEF.md
# SPI Register Access Master

This block is an SPI master that reads and writes registers in a peripheral whose transactions start with a header of variable length. A requester presents a 6-bit register id, a 15-bit sub-address, a direction flag, a byte count from 1 to 8 and up to 64 bits of write data. The block works out how many header bytes the sub-address needs (one, two or three) and shifts them out. It then either sends the write bytes or clocks in read bytes while sending zero. Read data comes back on a 64-bit word together with a one-cycle completion pulse.

The serial side runs in SPI mode 0: the clock idles low, data is sampled on the rising edge and changed on the falling edge, and each byte goes out most significant bit first. The serial clock is the system clock divided by a parameter. The chip select is active low. It is held for at least one half serial-clock period before the first edge and for at least one half period after the last edge. The peripheral's interrupt line passes through the block, which blocks it for as long as chip select is asserted.

Top module: `spiRegMaster`

## Requirements
- R1: After reset csN is 1, sclk is 0, busy is 0, done is 0 and rdData is all zero.
- R2: With a sub-address of zero the header is one byte: bit 7 is the write flag (1 = write), bit 6 is 0 and bits 5:0 carry the register id.
- R3: With a sub-address from 0x01 to 0x7F the header is two bytes. The first has bit 6 set, with the write flag in bit 7 and the id in bits 5:0. The second holds the sub-address in bits 6:0, with bit 7 clear.
- R4: With a sub-address above 0x7F the header is three bytes. The first is formed as in R3. The second holds sub-address bits 6:0 with bit 7 set, and the third holds sub-address bits 14:7.
- R5: On a write, after the header, exactly reqLen data bytes are sent. Byte k of the data phase is reqWData[8k+7:8k], so the least significant byte goes first. Every byte is sent MSB first.
- R6: On a read, after the header, reqLen bytes of 0x00 are sent. The byte captured during data byte k lands in rdData[8k+7:8k]. rdData is cleared to zero whenever a request is accepted, so bytes at and above reqLen read as zero (a 5-byte read leaves rdData[63:40] zero).
- R7: A request is accepted only when reqValid is 1, busy is 0 and reqLen is from 1 to 8. Otherwise it is ignored: no transaction starts and csN stays high.
- R8: SPI mode 0. sclk toggles only while csN is low and is low when csN falls. The first rising sclk edge comes at least CLK_HALF system cycles after csN falls, and csN rises at least CLK_HALF cycles after the last falling sclk edge.
- R9: done is a one-cycle pulse, issued once per transaction, in the cycle where csN returns high. rdData stays stable from then until the next accepted request.
- R10: irqOut equals devIrq while csN is high and is forced to 0 while csN is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| reqWrite | input | 1 | 1 = register write, 0 = read |
| reqRegId | input | 6 | Register id |
| reqSubAddr | input | 15 | Sub-address within the register |
| reqLen | input | 4 | Number of data bytes, 1 to 8 |
| reqWData | input | 64 | Write data, least significant byte sent first |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 64 | Read result |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the peripheral |
| csN | output | 1 | Active-low chip select |
| miso | input | 1 | Serial data from the peripheral |
| devIrq | input | 1 | Interrupt from the peripheral |
| irqOut | output | 1 | Interrupt after gating |

## Verification
The bench aims at the header-length boundaries: sub-address 0, 0x7F, 0x80 and 0x7FFF. A design that picks the wrong length would send a missing or extra byte, or leave the extended flag clear, and the captured wire bytes would then differ. Reads of 1, 2, 5 and 8 bytes test byte placement and clearing. A wrong order would swap bytes in rdData, and forgetting to clear would leave stale upper bytes after a short read. Requests made while busy, or with a length of 0 or 9, must leave the wire idle. A loose interrupt gate would let devIrq through while csN is low. Chip-select setup and hold times are measured on every transaction.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int REG_W   = 6;
  localparam int SUB_W   = 15;
  localparam int MAX_LEN = 8;
  localparam int DATA_W  = MAX_LEN * 8;
  localparam int LEN_W   = $clog2(MAX_LEN + 1);
  localparam int CNT_W   = $clog2(MAX_LEN + 4);
  localparam int IDX_W   = $clog2(DATA_W);

  typedef struct packed {
    logic             load;      // accept request, load first byte
    logic             sample;    // rising sclk: capture miso
    logic             shiftOut;  // falling sclk inside a byte
    logic             loadNext;  // falling sclk at byte end, more follow
    logic             store;     // byte finished
    logic [CNT_W-1:0] byteIdx;   // current wire byte
  } strobe_t;

  function automatic logic [1:0] hdrCount(input logic [SUB_W-1:0] sub);
    if (sub == '0)            return 2'd1;
    else if (sub > SUB_W'(127)) return 2'd3;
    else                      return 2'd2;
  endfunction

  function automatic logic [7:0] hdrByte(input logic wr, input logic [REG_W-1:0] regId,
                                         input logic [SUB_W-1:0] sub, input logic [1:0] idx);
    case (idx)
      2'd0:    return {wr, (sub != '0), regId};
      2'd1:    return {(sub > SUB_W'(127)), sub[6:0]};
      default: return sub[14:7];
    endcase
  endfunction
endpackage

// File: rtl/spiRegCtrl.sv
module spiRegCtrl
  import spi_reg_pkg::*;
#(
  parameter int CLK_HALF = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [LEN_W-1:0] reqLen,
  input  logic [CNT_W-1:0] totalBytes,
  output strobe_t          strb,
  output logic             busy,
  output logic             done,
  output logic             csN,
  output logic             sclk,
  output logic             irqBlock
);
  localparam int DIV_W = $clog2(CLK_HALF + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_SHIFT, ST_HOLD} state_t;
  state_t state;

  logic [DIV_W-1:0] divCnt;
  logic [CNT_W-1:0] byteIdx;
  logic [2:0]       bitIdx;
  logic             tick, accept, lastByte, lenOk;

  assign tick     = (divCnt == DIV_W'(CLK_HALF - 1));
  assign lenOk    = (reqLen != '0) && (reqLen <= LEN_W'(MAX_LEN));
  assign accept   = reqValid && (state == ST_IDLE) && lenOk;
  assign lastByte = (byteIdx == totalBytes - CNT_W'(1));
  assign busy     = (state != ST_IDLE);

  always_comb begin
    strb         = '0;
    strb.byteIdx = byteIdx;
    strb.load    = accept;
    if (state == ST_SHIFT && tick) begin
      if (!sclk) strb.sample = 1'b1;
      else if (bitIdx == 3'd7) begin
        strb.store    = 1'b1;
        strb.loadNext = !lastByte;
      end else strb.shiftOut = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      divCnt   <= '0;
      byteIdx  <= '0;
      bitIdx   <= '0;
      csN      <= 1'b1;
      sclk     <= 1'b0;
      done     <= 1'b0;
      irqBlock <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state == ST_IDLE) divCnt <= '0;
      else                  divCnt <= tick ? '0 : divCnt + DIV_W'(1);
      case (state)
        ST_IDLE: if (accept) begin
          state    <= ST_SETUP;
          csN      <= 1'b0;
          irqBlock <= 1'b1;
          byteIdx  <= '0;
          bitIdx   <= '0;
          sclk     <= 1'b0;
        end
        ST_SETUP: if (tick) state <= ST_SHIFT;
        ST_SHIFT: if (tick) begin
          sclk <= !sclk;
          if (sclk) begin
            if (bitIdx == 3'd7) begin
              bitIdx <= '0;
              if (lastByte) state <= ST_HOLD;
              else          byteIdx <= byteIdx + CNT_W'(1);
            end else bitIdx <= bitIdx + 3'd1;
          end
        end
        ST_HOLD: if (tick) begin
          state    <= ST_IDLE;
          csN      <= 1'b1;
          irqBlock <= 1'b0;
          done     <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8: clock moves only inside a selected transaction
  assert_sclk_selected_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sclk) |-> !csN);
  // R8: clock is idle low when chip select falls
  assert_cs_fall_low_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> !sclk);
  // R9: completion coincides with chip select release
  assert_done_release_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (csN && $past(!csN)));
  // R9: single-cycle pulse
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
endmodule

// File: rtl/spiRegDpath.sv
module spiRegDpath
  import spi_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              reqWrite,
  input  logic [REG_W-1:0]  reqRegId,
  input  logic [SUB_W-1:0]  reqSubAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [DATA_W-1:0] reqWData,
  input  logic              miso,
  output logic [CNT_W-1:0]  totalBytes,
  output logic              mosi,
  output logic [DATA_W-1:0] rdData
);
  logic              wrR;
  logic [REG_W-1:0]  regR;
  logic [SUB_W-1:0]  subR;
  logic [LEN_W-1:0]  lenR;
  logic [DATA_W-1:0] wdR;
  logic [1:0]        hdrLenR;
  logic [7:0]        txSh, rxSh, nextByte;
  logic [CNT_W-1:0]  nextIdx, curData, nxtData;
  logic [IDX_W-1:0]  nxtBase, curBase;

  assign totalBytes = CNT_W'(hdrLenR) + CNT_W'(lenR);
  assign mosi       = txSh[7];
  assign nextIdx    = strb.byteIdx + CNT_W'(1);
  assign nxtData    = nextIdx - CNT_W'(hdrLenR);
  assign curData    = strb.byteIdx - CNT_W'(hdrLenR);
  assign nxtBase    = {nxtData[2:0], 3'b000};
  assign curBase    = {curData[2:0], 3'b000};

  always_comb begin
    if (nextIdx < CNT_W'(hdrLenR)) nextByte = hdrByte(wrR, regR, subR, nextIdx[1:0]);
    else if (wrR)                  nextByte = wdR[nxtBase +: 8];
    else                           nextByte = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrR <= 1'b0; regR <= '0; subR <= '0; lenR <= '0; wdR <= '0;
      hdrLenR <= 2'd1; txSh <= '0; rxSh <= '0; rdData <= '0;
    end else if (strb.load) begin
      wrR     <= reqWrite;
      regR    <= reqRegId;
      subR    <= reqSubAddr;
      lenR    <= reqLen;
      wdR     <= reqWData;
      hdrLenR <= hdrCount(reqSubAddr);
      txSh    <= hdrByte(reqWrite, reqRegId, reqSubAddr, 2'd0);
      rdData  <= '0;
    end else begin
      if (strb.sample)   rxSh <= {rxSh[6:0], miso};
      if (strb.shiftOut) txSh <= {txSh[6:0], 1'b0};
      if (strb.loadNext) txSh <= nextByte;
      if (strb.store && !wrR && (strb.byteIdx >= CNT_W'(hdrLenR)))
        rdData[curBase +: 8] <= rxSh;
    end
  end

  // R6: no capture lands while a write is in flight
  assert_write_no_capture_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrR && !strb.load) |=> $stable(rdData));
endmodule

// File: rtl/spiRegMaster.sv
module spiRegMaster
  import spi_reg_pkg::*;
#(
  parameter int CLK_HALF = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [5:0]        reqRegId,
  input  logic [14:0]       reqSubAddr,
  input  logic [3:0]        reqLen,
  input  logic [63:0]       reqWData,
  output logic              busy,
  output logic              done,
  output logic [63:0]       rdData,
  output logic              sclk,
  output logic              mosi,
  output logic              csN,
  input  logic              miso,
  input  logic              devIrq,
  output logic              irqOut
);
  strobe_t          strb;
  logic [CNT_W-1:0] totalBytes;
  logic             irqBlock;

  spiRegCtrl #(.CLK_HALF(CLK_HALF)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLen(reqLen),
    .totalBytes(totalBytes), .strb(strb), .busy(busy), .done(done),
    .csN(csN), .sclk(sclk), .irqBlock(irqBlock)
  );

  spiRegDpath uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .reqWrite(reqWrite),
    .reqRegId(reqRegId), .reqSubAddr(reqSubAddr), .reqLen(reqLen),
    .reqWData(reqWData), .miso(miso), .totalBytes(totalBytes),
    .mosi(mosi), .rdData(rdData)
  );

  assign irqOut = devIrq && !irqBlock;

  // R10: interrupt never passes while the peripheral is selected
  assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rstN)
    !csN |-> !irqOut);
endmodule

// File: tb/sim_spiRegMaster.sv
`timescale 1ns/1ps
module sim_spiRegMaster;
  localparam int HALF = 2;
  localparam real TCLK = 5.0;

  typedef struct packed {
    logic        isWr;
    logic [5:0]  rid;
    logic [14:0] sub;
    logic [3:0]  len;
    logic [63:0] wd;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 6'h12, 15'h0000, 4'd4, 64'h0000_0000_DDCC_BBAA},
    '{1'b0, 6'h05, 15'h0000, 4'd5, 64'h0},
    '{1'b1, 6'h21, 15'h000C, 4'd2, 64'h0000_0000_0000_7E81},
    '{1'b0, 6'h3F, 15'h007F, 4'd1, 64'h0},
    '{1'b1, 6'h2E, 15'h0806, 4'd1, 64'h0000_0000_0000_00D5},
    '{1'b0, 6'h0A, 15'h7FFF, 4'd8, 64'h0},
    '{1'b0, 6'h11, 15'h0080, 4'd2, 64'h0}
  };

  logic clk = 0, rstN = 0;
  logic reqValid = 0, reqWrite = 0;
  logic [5:0] reqRegId = 0;
  logic [14:0] reqSubAddr = 0;
  logic [3:0] reqLen = 0;
  logic [63:0] reqWData = 0;
  logic busy, done, sclk, mosi, csN, miso, irqOut;
  logic [63:0] rdData;
  logic devIrq = 1;

  int errors = 0, checks = 0;
  bit finished = 0;

  always #(TCLK/2) clk = ~clk;

  spiRegMaster #(.CLK_HALF(HALF)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqRegId(reqRegId), .reqSubAddr(reqSubAddr), .reqLen(reqLen),
    .reqWData(reqWData), .busy(busy), .done(done), .rdData(rdData),
    .sclk(sclk), .mosi(mosi), .csN(csN), .miso(miso), .devIrq(devIrq),
    .irqOut(irqOut)
  );

  // ---- peripheral model ----
  function automatic logic [7:0] slvByte(input int j);
    return 8'hC3 ^ 8'(j * 29);
  endfunction
  function automatic logic slvBit(input int pos);
    logic [7:0] b;
    b = slvByte(pos / 8);
    return b[7 - (pos % 8)];
  endfunction

  logic [7:0] capBytes [16];
  logic [7:0] inSh = 0;
  int capCnt = 0, inBits = 0, outPos = 0, irqLeak = 0, doneCnt = 0;
  realtime tCsFall = 0, tFirstRise = 0, tLastFall = 0, tCsRise = 0;
  bit gotRise = 0;

  assign miso = slvBit(outPos);

  always @(negedge csN) begin
    capCnt = 0; inBits = 0; outPos = 0; gotRise = 0; tCsFall = $realtime;
  end
  always @(posedge csN) tCsRise = $realtime;
  always @(posedge sclk) if (!csN) begin
    if (!gotRise) begin tFirstRise = $realtime; gotRise = 1; end
    inSh = {inSh[6:0], mosi};
    inBits++;
    if (inBits == 8) begin
      if (capCnt < 16) capBytes[capCnt] = inSh;
      capCnt++;
      inBits = 0;
    end
  end
  always @(negedge sclk) if (!csN) begin
    outPos++;
    tLastFall = $realtime;
  end
  always @(negedge clk) begin
    if (rstN && !csN && irqOut) irqLeak++;
    if (done) doneCnt++;
  end

  // ---- helpers ----
  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic expWire(input vec_t v, output logic [7:0] eb [16], output int n,
                         output int hl);
    hl = (v.sub == 0) ? 1 : (v.sub > 15'h7F) ? 3 : 2;
    eb[0] = {v.isWr, (v.sub != 0), v.rid};
    if (hl > 1) eb[1] = {(v.sub > 15'h7F), v.sub[6:0]};
    if (hl > 2) eb[2] = v.sub[14:7];
    for (int k = 0; k < int'(v.len); k++)
      eb[hl + k] = v.isWr ? v.wd[k*8 +: 8] : 8'h00;
    n = hl + int'(v.len);
  endtask

  task automatic issue(input vec_t v);
    @(negedge clk);
    reqValid = 1; reqWrite = v.isWr; reqRegId = v.rid;
    reqSubAddr = v.sub; reqLen = v.len; reqWData = v.wd;
    @(negedge clk);
    reqValid = 0;
  endtask

  task automatic waitDone(input string req, output bit ok);
    ok = 0;
    for (int i = 0; i < 5000; i++) begin
      if (done) begin ok = 1; break; end
      @(negedge clk);
    end
    chk(ok, req, "done timeout", 64'(ok), 64'd1);
  endtask

  task automatic checkTxn(input vec_t v, input string req);
    logic [7:0] eb [16];
    int n, hl, d0;
    bit ok;
    logic [63:0] expRd;
    d0 = doneCnt;
    waitDone(req, ok);
    chk(csN == 1'b1, "R9", "csN at done", 64'(csN), 64'd1);
    expWire(v, eb, n, hl);
    chk(capCnt == n, req, "wire byte count", 64'(capCnt), 64'(n));
    for (int k = 0; k < n && k < 16; k++)
      chk(capBytes[k] == eb[k], (k < hl) ? req : (v.isWr ? "R5" : "R6"),
          $sformatf("wire byte %0d", k), 64'(capBytes[k]), 64'(eb[k]));
    expRd = '0;
    if (!v.isWr)
      for (int k = 0; k < int'(v.len); k++) expRd[k*8 +: 8] = slvByte(hl + k);
    chk(rdData == expRd, "R6", "rdData", rdData, expRd);
    chk((tFirstRise - tCsFall) >= HALF*TCLK, "R8", "cs setup ns",
        64'(int'(tFirstRise - tCsFall)), 64'(int'(HALF*TCLK)));
    chk((tCsRise - tLastFall) >= HALF*TCLK, "R8", "cs hold ns",
        64'(int'(tCsRise - tLastFall)), 64'(int'(HALF*TCLK)));
    repeat (3) @(negedge clk);
    chk(doneCnt - d0 == 1, "R9", "done pulses", 64'(doneCnt - d0), 64'd1);
  endtask

  // ---- watchdog ----
  initial begin
    #(TCLK * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL R9 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  // ---- main ----
  initial begin
    vec_t v;
    int c0;
    logic [63:0] held;
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk(csN == 1 && sclk == 0, "R1", "csN/sclk", {62'd0, csN, sclk}, 64'd2);
    chk(busy == 0 && done == 0, "R1", "busy/done", {62'd0, busy, done}, 64'd0);
    chk(rdData == 0, "R1", "rdData", rdData, 64'd0);
    // R10 pass-through while idle
    devIrq = 1; #1;
    chk(irqOut == 1, "R10", "irq idle high", 64'(irqOut), 64'd1);
    devIrq = 0; #1;
    chk(irqOut == 0, "R10", "irq idle low", 64'(irqOut), 64'd0);
    devIrq = 1;

    // table walk: R2 (sub 0), R3 (0x0C, 0x7F), R4 (0x806, 0x7FFF, 0x80)
    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      issue(v);
      checkTxn(v, (v.sub == 0) ? "R2" : (v.sub > 15'h7F) ? "R4" : "R3");
    end
    chk(irqLeak == 0, "R10", "irq leaked while selected", 64'(irqLeak), 64'd0);

    // R9: rdData stable after completion
    held = rdData;
    repeat (25) @(negedge clk);
    chk(rdData == held, "R9", "rdData held", rdData, held);

    // R7: zero length ignored
    c0 = capCnt;
    v = '{1'b0, 6'h01, 15'h0000, 4'd0, 64'h0};
    issue(v);
    chk(busy == 0 && csN == 1, "R7", "len 0 busy/csN", {62'd0, busy, csN}, 64'd1);
    repeat (10) @(negedge clk);
    chk(csN == 1 && capCnt == c0, "R7", "len 0 no wire", 64'(capCnt), 64'(c0));
    // R7: length 9 ignored
    v = '{1'b1, 6'h02, 15'h0003, 4'd9, 64'hFF};
    issue(v);
    chk(busy == 0 && csN == 1, "R7", "len 9 busy/csN", {62'd0, busy, csN}, 64'd1);
    chk(rdData == held, "R7", "len 9 rdData untouched", rdData, held);

    // R7: request while busy ignored
    v = VECS[0];
    issue(v);
    repeat (10) @(negedge clk);
    reqValid = 1; reqWrite = 0; reqRegId = 6'h33; reqSubAddr = 15'h0100; reqLen = 4'd3;
    @(negedge clk);
    reqValid = 0;
    checkTxn(v, "R7");
    repeat (6) @(negedge clk);
    chk(busy == 0 && csN == 1, "R7", "no second txn", {62'd0, busy, csN}, 64'd1);

    // R6: write after read clears rdData
    chk(rdData == 0, "R6", "cleared by write", rdData, 64'd0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule